// File: doc/BRIEF.md
# Event Context Stacking Sequencer

This block saves a processor context on the system stack when an event is taken and restores it when the event handler returns. On an accept pulse it captures the current status word, the return address and, for interrupt-level events, five general registers (R8 to R12) and the link register. It then writes them one word at a time through a single memory request port, moving the stack pointer down by one word before each write. A return command runs the reverse walk. It reads the frame back with the pointer moving up after each read, and presents the restored words on a one-cycle restore strobe.

The frame has one of two sizes. Exceptions store two words. The four interrupt levels store eight. At return time the block picks the frame size from the mode field of the status word that is current then. Before any push, the stack pointer minus the frame size is compared against a stack-limit input. If the frame would not fit, an overflow flag is raised. The pushes still run, because the system is in an undefined state anyway.

The memory request port follows valid/ready rules. A request holds valid, address, write enable and write data unchanged until ready is seen high, and that edge completes the transfer. Read data comes back later on a response strobe. Only one read is outstanding at a time, and the next request waits for the response.

Top module: `ctx_stack_seq`

## Requirements
- R1: After reset, busy_o, ovf_o, mem_req_valid_o and restore_valid_o are 0 and sp_o equals the SP_RESET parameter (default 0x100).
- R2: An accepted event with evt_is_irq_i=0 writes cur_pc_i to address sp-4 and then cur_sr_i to sp-8, leaving sp_o lowered by 8.
- R3: An accepted event with evt_is_irq_i=1 writes eight words to sp-4, sp-8, up to sp-32, in this order: PC, SR, LR, R12, R11, R10, R9, R8. ctx_regs_i holds word j at bits [32j+31:32j], with j=0..4 for R8..R12 and j=5 for LR. sp_o is left lowered by 32.
- R4: A return command reads the frame back in reverse order, raising sp_o by 4 after each read, and ends with sp_o at its pre-event value. The frame is the eight-word one when mode field cur_sr_i[24:22] is in 2..5, and the two-word one otherwise (for example 1 or 6).
- R5: After the last read, restore_valid_o is high for exactly one cycle, in the first cycle with busy_o low. In that cycle restore_pc_o and restore_sr_o hold the saved values. For an eight-word frame, restore_ext_o=1 and restore_regs_o holds the saved registers in the ctx_regs_i layout. For a two-word frame, restore_ext_o=0.
- R6: busy_o rises in the cycle after an accepted pulse and stays high until the last transfer completes. Accept and return pulses that arrive while busy_o is high are ignored. When accept and return arrive in the same idle cycle, the accept wins.
- R7: ovf_o is set when an accepted event finds sp minus the frame bytes (8 or 32) below stk_limit_i, unsigned, or below zero. The pushes still happen. ovf_o holds until the next accepted event or return command.
- R8: While mem_req_valid_o=1 and mem_req_ready_i=0, the valid, address, write enable and write data outputs stay unchanged. No new request is raised while a read response is pending.
- R9: Frames nest: two events followed by two returns restore the inner frame first, then the outer one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_accept_i | input | 1 | One-cycle pulse: an event was accepted |
| evt_is_irq_i | input | 1 | The accepted event is one of the four interrupt levels |
| ret_cmd_i | input | 1 | One-cycle pulse: return from event |
| cur_sr_i | input | 32 | Current status word (mode field at bits 24:22) |
| cur_pc_i | input | 32 | Return address to save |
| ctx_regs_i | input | 192 | R8..R12 and LR, 32 bits each |
| stk_limit_i | input | 32 | Lowest legal stack address |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request ready |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rvalid_i | input | 1 | Read response strobe |
| mem_rdata_i | input | 32 | Read response data |
| busy_o | output | 1 | A push or pop sequence is running |
| ovf_o | output | 1 | The last event frame did not fit above the limit |
| sp_o | output | 32 | System stack pointer |
| restore_valid_o | output | 1 | One-cycle strobe: restored context is ready |
| restore_ext_o | output | 1 | Restored frame included the registers |
| restore_sr_o | output | 32 | Restored status word |
| restore_pc_o | output | 32 | Restored return address |
| restore_regs_o | output | 192 | Restored R8..R12 and LR |

## Verification
If the slot counter or the frame-size bit goes wrong, the effect shows up within the same sequence. Writes land in the wrong order or at the wrong addresses, and the bench model's memory shows this as soon as busy_o falls. A bad stack pointer step shows as a wrong sp_o at that same idle cycle. It also shows one return later, when the restored words come from the wrong slots. A fault in the mode decode at return shows as a frame read with the wrong length, so sp_o misses its pre-event value on the first restore strobe. Lost back-pressure holding shows on the very cycle the request changes under a low ready.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PUSH     = 2'd1,
    ST_POP_REQ  = 2'd2,
    ST_POP_WAIT = 2'd3
  } seq_state_t;
endpackage

// File: rtl/ctx_frame_buf.sv
// Eight-slot frame store. Slot order is push order:
// 0 PC, 1 SR, 2 LR, 3 R12, 4 R11, 5 R10, 6 R9, 7 R8.
module ctx_frame_buf #(
  parameter int DATA_W = 32,
  parameter int N_EXT  = 8,
  parameter int SLOT_W = $clog2(N_EXT)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap_en,
  input  logic [DATA_W-1:0]             cap_pc,
  input  logic [DATA_W-1:0]             cap_sr,
  input  logic [(N_EXT-2)*DATA_W-1:0]   cap_regs,
  input  logic                          wr_en,
  input  logic [SLOT_W-1:0]             wr_slot,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [SLOT_W-1:0]             rd_slot,
  output logic [DATA_W-1:0]             rd_data,
  output logic [N_EXT*DATA_W-1:0]       slots_flat
);
  for (genvar s = 0; s < N_EXT; s++) begin : g_slot
    logic [DATA_W-1:0] cap_val;
    logic [DATA_W-1:0] word_q;
    if (s == 0) begin : g_pc
      assign cap_val = cap_pc;
    end else if (s == 1) begin : g_sr
      assign cap_val = cap_sr;
    end else begin : g_reg
      assign cap_val = cap_regs[(N_EXT-1-s)*DATA_W +: DATA_W];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  word_q <= '0;
      else if (cap_en)                             word_q <= cap_val;
      else if (wr_en && wr_slot == SLOT_W'(s))     word_q <= wr_data;
    end
    assign slots_flat[s*DATA_W +: DATA_W] = word_q;
  end

  assign rd_data = slots_flat[rd_slot*DATA_W +: DATA_W];
endmodule

// File: rtl/ctx_sp_unit.sv
// Stack pointer with pre-decrement push address and the room check.
module ctx_sp_unit #(
  parameter int                ADDR_W   = 32,
  parameter int                BYTES    = 4,
  parameter int                N_BASE   = 2,
  parameter int                N_EXT    = 8,
  parameter logic [ADDR_W-1:0] SP_RESET = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_en,
  input  logic              inc_en,
  input  logic              chk_en,
  input  logic              chk_ext,
  input  logic              clr_ovf,
  input  logic [ADDR_W-1:0] limit,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] push_addr,
  output logic              ovf
);
  localparam logic [ADDR_W:0] SPAN_BASE = (ADDR_W+1)'(N_BASE * BYTES);
  localparam logic [ADDR_W:0] SPAN_EXT  = (ADDR_W+1)'(N_EXT * BYTES);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(BYTES);

  logic [ADDR_W:0] proj;
  logic            ovf_nx;

  assign push_addr = sp - STEP;
  assign proj      = {1'b0, sp} - (chk_ext ? SPAN_EXT : SPAN_BASE);
  assign ovf_nx    = proj[ADDR_W] || (proj[ADDR_W-1:0] < limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp <= SP_RESET;
    else if (dec_en)  sp <= sp - STEP;
    else if (inc_en)  sp <= sp + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (chk_en)  ovf <= ovf_nx;
    else if (clr_ovf) ovf <= 1'b0;
  end

  // R2 / R3: every completed write lowers the pointer by one word
  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> sp == $past(sp) - STEP);
  // R4: every completed read raises it by one word
  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inc_en |=> sp == $past(sp) + STEP);
endmodule

// File: rtl/ctx_seq_fsm.sv
// Push/pop sequencer: walks slots up on push, down on pop.
module ctx_seq_fsm
  import ctx_pkg::*;
#(
  parameter int N_BASE = 2,
  parameter int N_EXT  = 8,
  parameter int SLOT_W = $clog2(N_EXT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_accept,
  input  logic              evt_is_irq,
  input  logic              ret_cmd,
  input  logic              ret_is_irq,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [SLOT_W-1:0] slot,
  output logic              busy,
  output logic              ext,
  output logic              cap_en,
  output logic              pop_wr,
  output logic              dec_en,
  output logic              inc_en,
  output logic              chk_en,
  output logic              clr_ovf,
  output logic              restore_valid
);
  localparam logic [SLOT_W-1:0] LAST_BASE = SLOT_W'(N_BASE - 1);
  localparam logic [SLOT_W-1:0] LAST_EXT  = SLOT_W'(N_EXT - 1);

  seq_state_t  state;
  logic        hs;
  logic        start_push;
  logic        start_pop;
  logic [SLOT_W-1:0] last_slot;

  always_comb begin
    mem_valid  = (state == ST_PUSH) || (state == ST_POP_REQ);
    mem_we     = (state == ST_PUSH);
    hs         = mem_valid && mem_ready;
    dec_en     = hs && mem_we;
    inc_en     = hs && !mem_we;
    pop_wr     = (state == ST_POP_WAIT) && mem_rvalid;
    start_push = (state == ST_IDLE) && evt_accept;
    start_pop  = (state == ST_IDLE) && !evt_accept && ret_cmd;
    cap_en     = start_push;
    chk_en     = start_push;
    clr_ovf    = start_pop;
    busy       = (state != ST_IDLE);
    last_slot  = ext ? LAST_EXT : LAST_BASE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      slot          <= '0;
      ext           <= 1'b0;
      restore_valid <= 1'b0;
    end else begin
      restore_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_push) begin
            ext   <= evt_is_irq;
            slot  <= '0;
            state <= ST_PUSH;
          end else if (start_pop) begin
            ext   <= ret_is_irq;
            slot  <= ret_is_irq ? LAST_EXT : LAST_BASE;
            state <= ST_POP_REQ;
          end
        end
        ST_PUSH: begin
          if (hs) begin
            if (slot == last_slot) state <= ST_IDLE;
            else                   slot  <= slot + 1'b1;
          end
        end
        ST_POP_REQ: begin
          if (hs) state <= ST_POP_WAIT;
        end
        ST_POP_WAIT: begin
          if (mem_rvalid) begin
            if (slot == '0) begin
              state         <= ST_IDLE;
              restore_valid <= 1'b1;
            end else begin
              slot  <= slot - 1'b1;
              state <= ST_POP_REQ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: a stalled request keeps its slot and direction
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(slot) && $stable(mem_we)));
  // R5: the restore strobe only follows the final read response
  assert_restore_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> ($past(state == ST_POP_WAIT) && $past(mem_rvalid)));
  // R6: a sequence only starts from a command pulse
  assert_busy_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(evt_accept || ret_cmd));
endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq #(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 32,
  parameter int                N_BASE    = 2,
  parameter int                N_EXT     = 8,
  parameter int                MODE_LSB  = 22,
  parameter int                MODE_W    = 3,
  parameter int                IRQ_LO    = 2,
  parameter int                IRQ_HI    = 5,
  parameter logic [ADDR_W-1:0] SP_RESET  = 'h100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         evt_accept_i,
  input  logic                         evt_is_irq_i,
  input  logic                         ret_cmd_i,
  input  logic [DATA_W-1:0]            cur_sr_i,
  input  logic [DATA_W-1:0]            cur_pc_i,
  input  logic [(N_EXT-2)*DATA_W-1:0]  ctx_regs_i,
  input  logic [ADDR_W-1:0]            stk_limit_i,
  output logic                         mem_req_valid_o,
  input  logic                         mem_req_ready_i,
  output logic                         mem_we_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  output logic [DATA_W-1:0]            mem_wdata_o,
  input  logic                         mem_rvalid_i,
  input  logic [DATA_W-1:0]            mem_rdata_i,
  output logic                         busy_o,
  output logic                         ovf_o,
  output logic [ADDR_W-1:0]            sp_o,
  output logic                         restore_valid_o,
  output logic                         restore_ext_o,
  output logic [DATA_W-1:0]            restore_sr_o,
  output logic [DATA_W-1:0]            restore_pc_o,
  output logic [(N_EXT-2)*DATA_W-1:0]  restore_regs_o
);
  localparam int SLOT_W = $clog2(N_EXT);
  localparam int BYTES  = DATA_W / 8;
  localparam int N_GPR  = N_EXT - 2;

  logic [MODE_W-1:0]       ret_mode;
  logic                    ret_is_irq;
  logic [SLOT_W-1:0]       slot;
  logic                    ext, cap_en, pop_wr, dec_en, inc_en, chk_en, clr_ovf;
  logic [ADDR_W-1:0]       push_addr;
  logic [N_EXT*DATA_W-1:0] slots_flat;

  assign ret_mode   = cur_sr_i[MODE_LSB +: MODE_W];
  assign ret_is_irq = (ret_mode >= MODE_W'(IRQ_LO)) && (ret_mode <= MODE_W'(IRQ_HI));

  ctx_seq_fsm #(.N_BASE(N_BASE), .N_EXT(N_EXT), .SLOT_W(SLOT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .evt_accept(evt_accept_i), .evt_is_irq(evt_is_irq_i),
    .ret_cmd(ret_cmd_i), .ret_is_irq(ret_is_irq),
    .mem_ready(mem_req_ready_i), .mem_rvalid(mem_rvalid_i),
    .mem_valid(mem_req_valid_o), .mem_we(mem_we_o),
    .slot(slot), .busy(busy_o), .ext(ext),
    .cap_en(cap_en), .pop_wr(pop_wr), .dec_en(dec_en), .inc_en(inc_en),
    .chk_en(chk_en), .clr_ovf(clr_ovf), .restore_valid(restore_valid_o)
  );

  ctx_sp_unit #(.ADDR_W(ADDR_W), .BYTES(BYTES), .N_BASE(N_BASE),
                .N_EXT(N_EXT), .SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_n),
    .dec_en(dec_en), .inc_en(inc_en),
    .chk_en(chk_en), .chk_ext(evt_is_irq_i), .clr_ovf(clr_ovf),
    .limit(stk_limit_i), .sp(sp_o), .push_addr(push_addr), .ovf(ovf_o)
  );

  ctx_frame_buf #(.DATA_W(DATA_W), .N_EXT(N_EXT), .SLOT_W(SLOT_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .cap_en(cap_en), .cap_pc(cur_pc_i), .cap_sr(cur_sr_i), .cap_regs(ctx_regs_i),
    .wr_en(pop_wr), .wr_slot(slot), .wr_data(mem_rdata_i),
    .rd_slot(slot), .rd_data(mem_wdata_o), .slots_flat(slots_flat)
  );

  assign mem_addr_o    = mem_we_o ? push_addr : sp_o;
  assign restore_ext_o = ext;
  assign restore_pc_o  = slots_flat[0 +: DATA_W];
  assign restore_sr_o  = slots_flat[DATA_W +: DATA_W];

  for (genvar j = 0; j < N_GPR; j++) begin : g_rst_reg
    assign restore_regs_o[j*DATA_W +: DATA_W] = slots_flat[(N_EXT-1-j)*DATA_W +: DATA_W];
  end

  // R8: address and data stay put under back-pressure
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      ($stable(mem_addr_o) && $stable(mem_wdata_o)));
endmodule

// File: tb/tb_ctx_stack_seq.sv
`timescale 1ns/1ps
module tb_ctx_stack_seq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         evt_accept_i = 1'b0, evt_is_irq_i = 1'b0, ret_cmd_i = 1'b0;
  logic [31:0]  cur_sr_i = '0, cur_pc_i = '0, stk_limit_i = '0;
  logic [191:0] ctx_regs_i = '0;
  logic         mem_req_valid_o, mem_req_ready_i, mem_we_o;
  logic [31:0]  mem_addr_o, mem_wdata_o;
  logic         mem_rvalid_i = 1'b0;
  logic [31:0]  mem_rdata_i = '0;
  logic         busy_o, ovf_o, restore_valid_o, restore_ext_o;
  logic [31:0]  sp_o, restore_sr_o, restore_pc_o;
  logic [191:0] restore_regs_o;

  always #10 clk = ~clk; // 50 MHz

  ctx_stack_seq dut (.*);

  // ---- memory model with optional back-pressure ----
  logic [31:0] mem [64];
  logic [31:0] cyc = '0;
  logic        stall_en = 1'b0;
  assign mem_req_ready_i = !stall_en || (cyc[1:0] == 2'b11);

  always @(posedge clk) begin
    cyc          <= cyc + 1;
    mem_rvalid_i <= 1'b0;
    if (mem_req_valid_o && mem_req_ready_i) begin
      if (mem_we_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
      else begin
        mem_rdata_i  <= mem[mem_addr_o[7:2]];
        mem_rvalid_i <= 1'b1;
      end
    end
  end

  int n_checks = 0, n_err = 0, hold_bad = 0;

  // R8 monitor, sampled away from the clock edge
  logic        prev_stalled = 1'b0, prev_we;
  logic [31:0] prev_addr, prev_wdata;
  always @(negedge clk) if (rst_n) begin
    if (prev_stalled && !(mem_req_valid_o && mem_addr_o == prev_addr &&
        mem_we_o == prev_we && (!prev_we || mem_wdata_o == prev_wdata)))
      hold_bad++;
    if (mem_rvalid_i && mem_req_valid_o) hold_bad++;
    prev_stalled = mem_req_valid_o && !mem_req_ready_i;
    prev_addr = mem_addr_o; prev_we = mem_we_o; prev_wdata = mem_wdata_o;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] regv(input logic [31:0] base, input int j);
    return base + 32'(j) * 32'h0101_0101;
  endfunction

  // snapshot of outputs in the first idle cycle
  logic        s_rv, s_ext;
  logic [31:0] s_pc, s_sr;
  logic [191:0] s_regs;

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 500) begin @(negedge clk); n++; end
    if (busy_o) check("R6 timeout", 32'(busy_o), 32'd0);
    s_rv = restore_valid_o; s_ext = restore_ext_o;
    s_pc = restore_pc_o; s_sr = restore_sr_o; s_regs = restore_regs_o;
  endtask

  task automatic set_ctx(input logic irq, input logic [31:0] sr, input logic [31:0] pc,
                         input logic [31:0] base);
    evt_is_irq_i = irq; cur_sr_i = sr; cur_pc_i = pc;
    for (int j = 0; j < 6; j++) ctx_regs_i[j*32 +: 32] = regv(base, j);
  endtask

  task automatic do_accept();
    evt_accept_i = 1'b1; @(negedge clk); evt_accept_i = 1'b0;
    wait_idle();
  endtask

  task automatic do_return(input logic [2:0] mode);
    cur_sr_i = {7'd0, mode, 22'h15_5555}; cur_pc_i = 32'hBAD0_BAD0;
    ctx_regs_i = {6{32'hFFFF_0000}};
    ret_cmd_i = 1'b1; @(negedge clk); ret_cmd_i = 1'b0;
    wait_idle();
  endtask

  // stimulus / expectation table: irq flag, saved SR, PC, register base,
  // mode field when returning, back-pressure on
  localparam int NV = 5;
  localparam bit          V_IRQ  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [31:0] V_SR   [NV] = '{32'h0040_0001, 32'h0000_0000, 32'h00C0_F00D,
                                          32'h0140_0002, 32'hFFFF_FFFF};
  localparam logic [31:0] V_PC   [NV] = '{32'h0000_1000, 32'h8000_0004, 32'hDEAD_BEEC,
                                          32'h0000_0ABC, 32'h1234_5678};
  localparam logic [31:0] V_BASE [NV] = '{32'h1000_0000, 32'h2000_0000, 32'h3000_0001,
                                          32'h4000_0000, 32'hA5A5_0000};
  localparam logic [2:0]  V_MODE [NV] = '{3'd2, 3'd6, 3'd5, 3'd1, 3'd4};
  localparam bit          V_STL  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] sp0, a_pc, b_pc;
    int nw;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy_o), 0);
    check("R1 ovf", 32'(ovf_o), 0);
    check("R1 valid", 32'(mem_req_valid_o), 0);
    check("R1 restore_valid", 32'(restore_valid_o), 0);
    check("R1 sp", sp_o, 32'h100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sp after release", sp_o, 32'h100);

    // table walk: R2 R3 R4 R5 R8
    for (int v = 0; v < NV; v++) begin
      stall_en = V_STL[v];
      sp0 = sp_o;
      nw  = V_IRQ[v] ? 8 : 2;
      set_ctx(V_IRQ[v], V_SR[v], V_PC[v], V_BASE[v]);
      evt_accept_i = 1'b1; @(negedge clk); evt_accept_i = 1'b0;
      check("R6 busy after accept", 32'(busy_o), 1);
      wait_idle();
      check(V_IRQ[v] ? "R3 sp after push" : "R2 sp after push", sp_o, sp0 - 32'(4*nw));
      check("R2 PC word", mem[5'(0) + 6'((sp0 - 4) >> 2)], V_PC[v]);
      check("R2 SR word", mem[6'((sp0 - 8) >> 2)], V_SR[v]);
      if (V_IRQ[v]) begin
        check("R3 LR word", mem[6'((sp0 - 12) >> 2)], regv(V_BASE[v], 5));
        for (int k = 3; k < 8; k++)
          check("R3 Rn word", mem[6'((sp0 - 32'(4*(k+1))) >> 2)], regv(V_BASE[v], 7 - k));
      end
      check("R7 no ovf", 32'(ovf_o), 0);
      do_return(V_MODE[v]);
      check("R4 sp after pop", sp_o, sp0);
      check("R5 strobe", 32'(s_rv), 1);
      check("R5 ext", 32'(s_ext), 32'(V_IRQ[v]));
      check("R5 pc", s_pc, V_PC[v]);
      check("R5 sr", s_sr, V_SR[v]);
      if (V_IRQ[v])
        for (int j = 0; j < 6; j++) check("R5 regs", s_regs[j*32 +: 32], regv(V_BASE[v], j));
      @(negedge clk);
      check("R5 strobe one cycle", 32'(restore_valid_o), 0);
    end
    stall_en = 1'b0;
    check("R8 hold and single read", 32'(hold_bad), 0);

    // R7 overflow on interrupt frame, pushes still performed
    stk_limit_i = 32'hFC;
    set_ctx(1'b1, 32'h11, 32'h22, 32'h3300_0000);
    do_accept();
    check("R7 ovf set", 32'(ovf_o), 1);
    check("R7 pushes still done", sp_o, 32'hE0);
    do_return(3'd3);
    check("R7 ovf cleared by return", 32'(ovf_o), 0);
    // R7 boundary: exactly fits
    stk_limit_i = 32'hF8;
    set_ctx(1'b0, 32'h1, 32'h2, 32'h0);
    do_accept();
    check("R7 exact fit no ovf", 32'(ovf_o), 0);
    do_return(3'd6);
    stk_limit_i = 32'hF9;
    do_accept();
    check("R7 one byte short ovf", 32'(ovf_o), 1);
    do_return(3'd6);
    stk_limit_i = 32'h0;

    // R6 accept while busy ignored
    set_ctx(1'b0, 32'h5, 32'h6, 32'h0);
    evt_accept_i = 1'b1; @(negedge clk);
    check("R6 busy", 32'(busy_o), 1);
    @(negedge clk); evt_accept_i = 1'b0;
    wait_idle();
    check("R6 second accept ignored", sp_o, 32'hF8);
    do_return(3'd6);
    check("R6 sp restored", sp_o, 32'h100);

    // R6 accept beats return in same cycle
    set_ctx(1'b0, 32'h7, 32'h8, 32'h0);
    evt_accept_i = 1'b1; ret_cmd_i = 1'b1; @(negedge clk);
    evt_accept_i = 1'b0; ret_cmd_i = 1'b0;
    wait_idle();
    check("R6 accept wins sp", sp_o, 32'hF8);
    check("R6 accept wins no restore", 32'(s_rv), 0);
    do_return(3'd1);

    // R9 nesting
    a_pc = 32'hAAAA_0010; b_pc = 32'hBBBB_0020;
    set_ctx(1'b1, 32'h0080_0000, a_pc, 32'h5000_0000);
    do_accept();
    set_ctx(1'b0, 32'h00C0_0000, b_pc, 32'h6000_0000);
    do_accept();
    check("R9 nested sp", sp_o, 32'hD8);
    do_return(3'd6);
    check("R9 inner pc first", s_pc, b_pc);
    check("R9 inner sp", sp_o, 32'hE0);
    do_return(3'd3);
    check("R9 outer pc", s_pc, a_pc);
    check("R9 outer r8", s_regs[31:0], regv(32'h5000_0000, 0));
    check("R9 outer sp", sp_o, 32'h100);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule